// File: doc/BRIEF.md
# Single-Step Trap Sequencer

This block decides when a processor core raises a single-step debug trap and when an instruction breakpoint must stay quiet on resume. The core drives four event strobes: one instruction retired, flags written (as by a pop-flags instruction), exception entered, and exception returned. A flags write or an exception return carries a full flags word. The block holds the architectural trap flag and resume flag, and it keeps one extra bit that records whether stepping is armed for the instruction now executing.

The trap flag does not act on the instruction that sets it. Stepping is armed only when an instruction retires with the flag set, so the first step trap comes after the following instruction. The resume flag is loaded only by an exception return. It masks breakpoint matches until one instruction retires cleanly. The trap request and a per-cycle cause word are combinational from the current state and the strobes of the same cycle. The core can therefore take the trap in the cycle of the retire.

Top module: `sst_trap_seq`

## Requirements
- R1: After reset the trap flag, the resume flag and the armed state are clear. With no strobes active, `dbg_trap_o` is 0 and `dbg_status_o` is 0.
- R2: A flags write not masked by exception entry loads the trap flag from bit 8 of `flags_wdata_i` and leaves the resume flag unchanged. All other data bits have no effect.
- R3: An exception return not masked by exception entry loads the trap flag from data bit 8 and the resume flag from data bit 16.
- R4: A step trap is raised in a cycle with `retire_i` high if the trap flag was set at the end of the last retire, counting a load made in that same retire cycle. It is never raised in a cycle without `retire_i`.
- R5: The instruction whose retire cycle sets the trap flag, by a write or by a return, is not trapped. The next retired instruction is trapped.
- R6: Exception entry clears the trap flag, the resume flag and the armed state. It overrides a write or return in the same cycle and forces `dbg_trap_o` and `dbg_status_o` to 0 in that cycle.
- R7: A breakpoint match on `bp_hit_i[k]` raises a trap with status bit k only while the resume flag is clear.
- R8: The resume flag clears at the end of a cycle with `retire_i` high, unless an exception return in that cycle reloads it.
- R9: Status bit 14 reports a step trap and bits [N_BP-1:0] report unmasked breakpoint matches. All other status bits are 0. `dbg_trap_o` is the OR of the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | One instruction retires this cycle |
| flags_wr_i | input | 1 | Flags write carrying `flags_wdata_i` |
| exc_return_i | input | 1 | Exception return restoring `flags_wdata_i` |
| exc_enter_i | input | 1 | Exception entry in progress |
| flags_wdata_i | input | FLAGS_W | New flags word |
| bp_hit_i | input | N_BP | Instruction breakpoint matches |
| dbg_trap_o | output | 1 | Debug trap request |
| dbg_status_o | output | STAT_W | Cause word for this cycle |
| tf_o | output | 1 | Current trap flag |
| rf_o | output | 1 | Current resume flag |

## Verification
The bench steps through every combination of the four strobes, the two meaningful data bits and the breakpoint matches, in permuted orders, so that each combination meets varied prior state. The corner cases are these:
- A flags write that sets the trap flag. A design without the one-instruction delay traps the popping instruction itself.
- A write that clears the trap flag while stepping is armed. A design that arms from the live flag misses the trap owed to that instruction.
- A retire coinciding with a return. A design that clears the resume flag last loses the freshly restored mask and re-hits the breakpoint.
- Entry coinciding with a write or return. A design that lets the load win lets the handler step itself.

The data words carry noise in every bit other than 8 and 16, which exposes a design that decodes the wrong bit.

// File: rtl/sst_pkg.sv
package sst_pkg;

   // one decoded flag update for the current cycle
   typedef struct packed {
      logic clear;   // exception entry: wipe everything
      logic ld_tf;   // load trap flag
      logic ld_rf;   // load resume flag
      logic tf_val;
      logic rf_val;
   } flag_cmd_t;

   function automatic flag_cmd_t decode_cmd(input logic enter,
                                            input logic wr,
                                            input logic ret,
                                            input logic tf_bit,
                                            input logic rf_bit);
      flag_cmd_t c;
      c.clear  = enter;
      c.ld_tf  = !enter && (wr || ret);
      c.ld_rf  = !enter && ret;
      c.tf_val = tf_bit;
      c.rf_val = rf_bit;
      return c;
   endfunction

endpackage

// File: rtl/sst_flag_reg.sv
module sst_flag_reg
   import sst_pkg::*;
#(
   parameter int FLAGS_W = 32,
   parameter int TF_BIT  = 8,
   parameter int RF_BIT  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               retire,
   input  logic               flags_wr,
   input  logic               exc_return,
   input  logic               exc_enter,
   input  logic [FLAGS_W-1:0] wdata,
   output logic               tf,
   output logic               rf,
   output logic               tf_next
);

   flag_cmd_t cmd;
   logic      rf_next;
   logic      unused_wdata_bits;

   assign unused_wdata_bits = ^wdata;

   always_comb begin
      cmd = decode_cmd(exc_enter, flags_wr, exc_return,
                       wdata[TF_BIT], wdata[RF_BIT]);
   end

   // trap flag value after this cycle's update
   always_comb begin
      if (cmd.clear)      tf_next = 1'b0;
      else if (cmd.ld_tf) tf_next = cmd.tf_val;
      else                tf_next = tf;
   end

   // resume flag: a reload wins over the retire auto-clear
   always_comb begin
      if (cmd.clear)      rf_next = 1'b0;
      else if (cmd.ld_rf) rf_next = cmd.rf_val;
      else if (retire)    rf_next = 1'b0;
      else                rf_next = rf;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tf <= 1'b0;
         rf <= 1'b0;
      end else begin
         tf <= tf_next;
         rf <= rf_next;
      end
   end

endmodule

// File: rtl/sst_step_arm.sv
module sst_step_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic retire,
   input  logic exc_enter,
   input  logic tf_next,
   output logic step_fire
);

   // armed: trap flag was set when the last instruction retired
   logic armed;

   assign step_fire = retire && armed && !exc_enter;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         armed <= 1'b0;
      else if (exc_enter) armed <= 1'b0;
      else if (retire)    armed <= tf_next;
   end

endmodule

// File: rtl/sst_bp_gate.sv
module sst_bp_gate #(
   parameter int N_BP = 4
) (
   input  logic [N_BP-1:0] hit,
   input  logic            rf,
   input  logic            exc_enter,
   output logic [N_BP-1:0] fire
);

   for (genvar k = 0; k < N_BP; k++) begin : g_slot
      assign fire[k] = hit[k] && !rf && !exc_enter;
   end

endmodule

// File: rtl/sst_trap_seq.sv
module sst_trap_seq #(
   parameter int FLAGS_W = 32,
   parameter int TF_BIT  = 8,
   parameter int RF_BIT  = 16,
   parameter int N_BP    = 4,
   parameter int STAT_W  = 16,
   parameter int BS_BIT  = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               retire_i,
   input  logic               flags_wr_i,
   input  logic               exc_return_i,
   input  logic               exc_enter_i,
   input  logic [FLAGS_W-1:0] flags_wdata_i,
   input  logic [N_BP-1:0]    bp_hit_i,
   output logic               dbg_trap_o,
   output logic [STAT_W-1:0]  dbg_status_o,
   output logic               tf_o,
   output logic               rf_o
);

   localparam int BP_TOP = N_BP - 1;

   if (TF_BIT >= FLAGS_W || RF_BIT >= FLAGS_W) begin : g_bad_flag_pos
      $error("flag bit position outside flags word");
   end
   if (TF_BIT == RF_BIT) begin : g_bad_flag_alias
      $error("trap and resume flags share a bit");
   end
   if (BS_BIT >= STAT_W || N_BP < 1 || N_BP > BS_BIT) begin : g_bad_status
      $error("status layout does not fit");
   end

   logic            tf_q, rf_q, tf_nx, step_fire;
   logic [N_BP-1:0] bp_fire;

   sst_flag_reg #(
      .FLAGS_W(FLAGS_W), .TF_BIT(TF_BIT), .RF_BIT(RF_BIT)
   ) i_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .retire    (retire_i),
      .flags_wr  (flags_wr_i),
      .exc_return(exc_return_i),
      .exc_enter (exc_enter_i),
      .wdata     (flags_wdata_i),
      .tf        (tf_q),
      .rf        (rf_q),
      .tf_next   (tf_nx)
   );

   sst_step_arm i_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .retire   (retire_i),
      .exc_enter(exc_enter_i),
      .tf_next  (tf_nx),
      .step_fire(step_fire)
   );

   sst_bp_gate #(.N_BP(N_BP)) i_bp (
      .hit      (bp_hit_i),
      .rf       (rf_q),
      .exc_enter(exc_enter_i),
      .fire     (bp_fire)
   );

   // status word assembly, one bit at a time
   for (genvar b = 0; b < STAT_W; b++) begin : g_stat
      if (b == BS_BIT) begin : g_bs
         assign dbg_status_o[b] = step_fire;
      end else if (b <= BP_TOP) begin : g_bp
         assign dbg_status_o[b] = bp_fire[b];
      end else begin : g_zero
         assign dbg_status_o[b] = 1'b0;
      end
   end

   assign dbg_trap_o = |dbg_status_o;
   assign tf_o       = tf_q;
   assign rf_o       = rf_q;

endmodule

// File: rtl/sst_trap_seq_chk.sv
module sst_trap_seq_chk #(
   parameter int FLAGS_W = 32,
   parameter int TF_BIT  = 8,
   parameter int RF_BIT  = 16,
   parameter int N_BP    = 4,
   parameter int STAT_W  = 16,
   parameter int BS_BIT  = 14
) (
   input logic               clk,
   input logic               rst_n,
   input logic               retire_i,
   input logic               flags_wr_i,
   input logic               exc_return_i,
   input logic               exc_enter_i,
   input logic [FLAGS_W-1:0] flags_wdata_i,
   input logic [N_BP-1:0]    bp_hit_i,
   input logic               dbg_trap_o,
   input logic [STAT_W-1:0]  dbg_status_o,
   input logic               tf_o,
   input logic               rf_o
);

   localparam logic [STAT_W-1:0] USED_MASK =
      (STAT_W'(1) << BS_BIT) | ((STAT_W'(1) << N_BP) - STAT_W'(1));

   logic unused_chk_bits;
   assign unused_chk_bits = ^flags_wdata_i;

   // R2
   wr_loads_tf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_wr_i && !exc_enter_i) |=> (tf_o == $past(flags_wdata_i[TF_BIT])));

   // R2
   wr_keeps_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_wr_i && !exc_return_i && !exc_enter_i && !retire_i) |=> $stable(rf_o));

   // R3
   ret_loads_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_return_i && !exc_enter_i) |=> (rf_o == $past(flags_wdata_i[RF_BIT])));

   // R4
   step_needs_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_status_o[BS_BIT] |-> retire_i);

   // R6
   entry_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_enter_i |=> (!tf_o && !rf_o));

   // R6
   entry_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_enter_i |-> (!dbg_trap_o && dbg_status_o == '0));

   // R7
   bp_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_o |-> (dbg_status_o[N_BP-1:0] == '0));

   // R7
   bp_passed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rf_o && !exc_enter_i) |-> (dbg_status_o[N_BP-1:0] == bp_hit_i));

   // R8
   rf_autoclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_i && !exc_return_i) |=> !rf_o);

   // R9
   status_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dbg_status_o & ~USED_MASK) == '0) && (dbg_trap_o == (dbg_status_o != '0)));

endmodule

bind sst_trap_seq sst_trap_seq_chk #(
   .FLAGS_W(FLAGS_W), .TF_BIT(TF_BIT), .RF_BIT(RF_BIT),
   .N_BP(N_BP), .STAT_W(STAT_W), .BS_BIT(BS_BIT)
) i_sst_chk (.*);

// File: tb/test_sst_trap_seq.sv
module test_sst_trap_seq;

   localparam int FW = 32, NB = 4, SW = 16;
   localparam int TFB = 8, RFB = 16, BSB = 14;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          retire_i = 0, flags_wr_i = 0, exc_return_i = 0, exc_enter_i = 0;
   logic [FW-1:0] flags_wdata_i = '0;
   logic [NB-1:0] bp_hit_i = '0;
   logic          dbg_trap_o, tf_o, rf_o;
   logic [SW-1:0] dbg_status_o;

   int  n_chk = 0, n_bad = 0;
   bit  done = 0;
   bit  m_tf = 0, m_rf = 0, m_arm = 0;   // bench model state

   always #5 clk = ~clk;

   sst_trap_seq i_sst_trap_seq (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // v: [0]retire [1]write [2]return [3]enter [4]tf bit [5]rf bit [9:6]hits
   task automatic apply(input logic [9:0] v, input string tag);
      bit r, w, rt, e, dtf, drf, s, tn;
      logic [NB-1:0]  hits, bpx;
      logic [SW-1:0]  st;
      logic [FW-1:0]  wd;
      r = v[0]; w = v[1]; rt = v[2]; e = v[3]; dtf = v[4]; drf = v[5]; hits = v[9:6];
      wd = 32'hA5C3_5A3C ^ ({22'd0, v} * 32'h0101_0101);
      wd[TFB] = dtf; wd[RFB] = drf;
      @(negedge clk);
      retire_i = r; flags_wr_i = w; exc_return_i = rt; exc_enter_i = e;
      flags_wdata_i = wd; bp_hit_i = hits;
      #2;
      s   = r && m_arm && !e;
      bpx = (e || m_rf) ? '0 : hits;
      st  = '0; st[BSB] = s; st[NB-1:0] = bpx;
      chk({tag, " status"}, 32'(dbg_status_o), 32'(st));
      chk({tag, " trap"}, 32'(dbg_trap_o), 32'(st != '0));
      chk({tag, " tf"}, 32'(tf_o), 32'(m_tf));
      chk({tag, " rf"}, 32'(rf_o), 32'(m_rf));
      if (e) begin
         m_tf = 0; m_rf = 0; m_arm = 0;
      end else begin
         tn = (w || rt) ? dtf : m_tf;
         if (rt)     m_rf = drf;
         else if (r) m_rf = 0;
         m_tf = tn;
         if (r) m_arm = tn;
      end
   endtask

   task automatic idle(input string tag);
      apply(10'd0, tag);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: quiet after reset, also with a breakpoint hit that must pass
      idle("R1");
      apply(10'b1111_000001, "R1 hit");
      // R5: write setting tf retires untrapped, next retire traps (R4)
      apply(10'b0000_010011, "R5 set");
      apply(10'b0000_000001, "R5 next");
      apply(10'b0000_000001, "R4 again");
      // R2: write clearing tf while armed still owes one trap
      apply(10'b0000_100011, "R2 clear");
      apply(10'b0000_000001, "R4 quiet");
      // R3: return restores tf and rf; R7 mask; R8 clear after retire
      apply(10'b0000_110101, "R3 ret");
      apply(10'b1010_000000, "R7 masked");
      apply(10'b1010_000001, "R8 retire");
      apply(10'b1010_000000, "R7 open");
      // R8: retire together with return keeps the reloaded rf
      apply(10'b0000_100101, "R8 reload");
      idle("R8 kept");
      // R6: entry with write, return and retire while armed
      apply(10'b0000_010011, "R6 arm");
      apply(10'b1111_111111, "R6 entry");
      apply(10'b1111_000001, "R6 after");
      // near-exhaustive sweep: permuted orders of all 1024 input vectors
      for (int p = 0; p < 3; p++) begin
         for (int i = 0; i < 1024; i++) begin
            apply(10'((i * 709 + p * 311) & 10'h3FF), "R9 sweep");
         end
      end
      idle("R9 end");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule